// File: doc/BRIEF.md
# Frame Buffer Pixel Unpacker with Palette Lookup

This block sits between the display fetch engine and the panel pipeline. It accepts 32-bit frame buffer words over a valid/ready handshake and slices each word into encoded pixels of 1, 2, 4, 8 or 16 bits. It works upward from the least significant bit. Pixels of 1 to 8 bits index a 256-entry by 16-bit color palette. Pixels of 16 bits skip the palette and pass through unchanged. Every output pixel carries a route flag. The flag selects either the temporal dithering path used by passive panels or the direct data path used by active panels.

Software loads the palette between frames through a write port. A frame begins with a one-cycle start pulse, which also latches the pixel depth, panel type and color/monochrome setting for the whole frame. The frame ends when the final pixel of the word flagged as last has left the output. The palette read costs one cycle. Output backpressure stalls the whole pipe without dropping or repeating pixels.

Top module: `pix_unpack_pal`

## Requirements
- R1: While reset is held, out_valid_o, out_last_o and in_ready_o are 0. in_ready_o stays 0 until a frame has been started.
- R2: The depth code selects the pixel width: 0 gives 1 bit, 1 gives 2, 2 gives 4, 3 gives 8 and 4 gives 16. Codes 5 to 7 act as 16 bits. A word yields 32/width pixels, and pixel j comes from bits [j*width +: width].
- R3: A 1-, 2- or 4-bit pixel value, zero-extended, addresses the palette, so only entries 0–1, 0–3 or 0–15 are reachable.
- R4: An 8-bit pixel addresses any of the 256 palette entries.
- R5: At 16-bit depth the palette is not used, and the output pixel equals the 16 encoded bits.
- R6: With color_mode_i latched at 0 (monochrome), a palette result is output as {8'h00, entry[7:0]}. With 1 it is the full 16-bit entry. Bypassed 16-bit pixels are never masked.
- R7: out_direct_o equals the latched active_panel_i. It is 1 for the direct panel data path and 0 for the dithering path, at every depth including 16-bit.
- R8: While out_valid_o is high and out_ready_i is low, out_pixel_o, out_direct_o and out_last_o hold. The pixel sequence has no loss and no duplication under any ready pattern.
- R9: A palette write is accepted (pal_wack_o=1) only while no frame is active. A refused write leaves the palette unchanged.
- R10: The depth, panel type and color settings are sampled only on frame_start_i. Changes to them during a frame have no effect.
- R11: out_last_o marks the final pixel of the word sent with in_last_i. in_ready_o stays 0 after that word is taken. Once that pixel is accepted, the frame is inactive and the output is empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| frame_start_i | input | 1 | One-cycle pulse that opens a frame and latches the mode |
| depth_sel_i | input | 3 | Pixel depth code |
| active_panel_i | input | 1 | 1 selects active panel routing, 0 selects passive |
| color_mode_i | input | 1 | 1 for color, 0 for monochrome palette output |
| pal_we_i | input | 1 | Palette write request |
| pal_waddr_i | input | 8 | Palette write index |
| pal_wdata_i | input | 16 | Palette write data |
| pal_wack_o | output | 1 | Write accepted this cycle |
| in_valid_i | input | 1 | Frame buffer word valid |
| in_data_i | input | 32 | Frame buffer word |
| in_last_i | input | 1 | Word is the last of the frame |
| in_ready_o | output | 1 | Word accepted when valid and ready |
| out_valid_o | output | 1 | Pixel valid |
| out_ready_i | input | 1 | Downstream ready |
| out_pixel_o | output | 16 | Pixel color value |
| out_direct_o | output | 1 | 1 routes to panel data path, 0 to dithering path |
| out_last_o | output | 1 | Final pixel of the frame |

## Verification
The assertions check four things on every cycle. The output holds while stalled. The pipe is empty whenever a palette write lands. The frame drains completely after its last pixel. Unpacked codes never exceed the selected width. The bench's scenarios cover the rest by sweeping every depth against both panel types and both color settings under a pseudo-random ready pattern. These scenarios show the extraction order, the palette addressing, monochrome masking, routing, mode latching at frame start, and refusal of writes issued mid-frame.

// File: rtl/pix_pkg.sv
package pix_pkg;
  typedef enum logic [2:0] {
    D1  = 3'd0,
    D2  = 3'd1,
    D4  = 3'd2,
    D8  = 3'd3,
    D16 = 3'd4
  } depth_e;
endpackage

// File: rtl/pix_unpack.sv
module pix_unpack
  import pix_pkg::*;
#(
  parameter int WORD_W = 32,
  parameter int CODE_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  depth_e            depth_i,
  input  logic              load_i,
  input  logic [WORD_W-1:0] word_i,
  input  logic              last_i,
  input  logic              take_i,
  output logic              valid_o,
  output logic [CODE_W-1:0] code_o,
  output logic              last_o,
  output logic              room_o
);
  localparam int CNT_W = $clog2(WORD_W) + 1;

  logic [WORD_W-1:0] word_q;
  logic [CNT_W-1:0]  cnt_q;
  logic              last_q;
  logic [4:0]        bits;
  logic [CNT_W-1:0]  per_word;
  logic [CODE_W-1:0] mask;

  assign bits     = 5'd1 << depth_i;
  assign per_word = CNT_W'(WORD_W >> depth_i);
  assign mask     = {CODE_W{1'b1}} >> (CODE_W - int'(bits));

  assign valid_o = cnt_q != '0;
  assign code_o  = word_q[CODE_W-1:0] & mask;
  assign last_o  = last_q && (cnt_q == CNT_W'(1));
  // refill allowed when empty or when the final pixel leaves this cycle
  assign room_o  = !valid_o || ((cnt_q == CNT_W'(1)) && take_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      word_q <= '0;
      cnt_q  <= '0;
      last_q <= 1'b0;
    end else if (load_i) begin
      word_q <= word_i;
      cnt_q  <= per_word;
      last_q <= last_i;
    end else if (take_i && valid_o) begin
      word_q <= word_q >> bits;
      cnt_q  <= cnt_q - 1'b1;
    end
  end

  assert_code_fits_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> ((code_o >> bits) == '0));
endmodule

// File: rtl/pix_lookup.sv
module pix_lookup #(
  parameter int ADDR_W = 8,
  parameter int PIX_W  = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] waddr_i,
  input  logic [PIX_W-1:0]  wdata_i,
  input  logic              adv_i,
  input  logic              in_valid_i,
  input  logic [PIX_W-1:0]  code_i,
  input  logic              in_last_i,
  input  logic              bypass_i,
  input  logic              mono_i,
  input  logic              direct_i,
  output logic              out_valid_o,
  output logic [PIX_W-1:0]  pixel_o,
  output logic              direct_o,
  output logic              last_o
);
  localparam int ENTRIES = 1 << ADDR_W;
  localparam int HALF    = PIX_W / 2;

  logic [PIX_W-1:0] mem [ENTRIES];
  logic [PIX_W-1:0] rd_q, code_q;
  logic             valid_q, last_q, bypass_q, mono_q, direct_q;

  always_ff @(posedge clk_i) begin
    if (we_i) mem[waddr_i] <= wdata_i;
  end

  // sync read, stage enable shared with the output register
  always_ff @(posedge clk_i) begin
    if (adv_i && in_valid_i) begin
      rd_q   <= mem[code_i[ADDR_W-1:0]];
      code_q <= code_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q  <= 1'b0;
      last_q   <= 1'b0;
      bypass_q <= 1'b0;
      mono_q   <= 1'b0;
      direct_q <= 1'b0;
    end else if (adv_i) begin
      valid_q  <= in_valid_i;
      last_q   <= in_valid_i && in_last_i;
      bypass_q <= bypass_i;
      mono_q   <= mono_i;
      direct_q <= direct_i;
    end
  end

  assign out_valid_o = valid_q;
  assign last_o      = last_q;
  assign direct_o    = direct_q;
  assign pixel_o     = bypass_q ? code_q :
                       mono_q   ? {{(PIX_W-HALF){1'b0}}, rd_q[HALF-1:0]} : rd_q;

  assert_stall_hold_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_q && !adv_i) |=> (valid_q && $stable(pixel_o) && $stable(last_q) && $stable(direct_q)));

  assert_write_idle_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_i |-> (!valid_q && !in_valid_i));
endmodule

// File: rtl/pix_unpack_pal.sv
module pix_unpack_pal
  import pix_pkg::*;
#(
  parameter int WORD_W = 32,
  parameter int PIX_W  = 16,
  parameter int ADDR_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              frame_start_i,
  input  logic [2:0]        depth_sel_i,
  input  logic              active_panel_i,
  input  logic              color_mode_i,
  input  logic              pal_we_i,
  input  logic [ADDR_W-1:0] pal_waddr_i,
  input  logic [PIX_W-1:0]  pal_wdata_i,
  output logic              pal_wack_o,
  input  logic              in_valid_i,
  input  logic [WORD_W-1:0] in_data_i,
  input  logic              in_last_i,
  output logic              in_ready_o,
  output logic              out_valid_o,
  input  logic              out_ready_i,
  output logic [PIX_W-1:0]  out_pixel_o,
  output logic              out_direct_o,
  output logic              out_last_o
);
  depth_e depth_q, depth_in;
  logic   active_q, color_q, frame_q, got_last_q;
  logic   adv, in_fire, out_fire, room;
  logic   pix_valid, pix_last;
  logic [PIX_W-1:0] pix_code;

  assign depth_in = (depth_sel_i > 3'd4) ? D16 : depth_e'(depth_sel_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      depth_q    <= D1;
      active_q   <= 1'b0;
      color_q    <= 1'b0;
      frame_q    <= 1'b0;
      got_last_q <= 1'b0;
    end else if (frame_start_i) begin
      depth_q    <= depth_in;
      active_q   <= active_panel_i;
      color_q    <= color_mode_i;
      frame_q    <= 1'b1;
      got_last_q <= 1'b0;
    end else begin
      if (in_fire && in_last_i) got_last_q <= 1'b1;
      if (out_fire && out_last_o) frame_q <= 1'b0;
    end
  end

  assign pal_wack_o = pal_we_i && !frame_q;
  assign adv        = !out_valid_o || out_ready_i;
  assign in_ready_o = frame_q && !got_last_q && room;
  assign in_fire    = in_valid_i && in_ready_o;
  assign out_fire   = out_valid_o && out_ready_i;

  pix_unpack #(.WORD_W(WORD_W), .CODE_W(PIX_W)) u_unpack (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .depth_i (depth_q),
    .load_i  (in_fire),
    .word_i  (in_data_i),
    .last_i  (in_last_i),
    .take_i  (adv),
    .valid_o (pix_valid),
    .code_o  (pix_code),
    .last_o  (pix_last),
    .room_o  (room)
  );

  pix_lookup #(.ADDR_W(ADDR_W), .PIX_W(PIX_W)) u_lookup (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .we_i        (pal_wack_o),
    .waddr_i     (pal_waddr_i),
    .wdata_i     (pal_wdata_i),
    .adv_i       (adv),
    .in_valid_i  (pix_valid),
    .code_i      (pix_code),
    .in_last_i   (pix_last),
    .bypass_i    (depth_q == D16),
    .mono_i      (!color_q),
    .direct_i    (active_q),
    .out_valid_o (out_valid_o),
    .pixel_o     (out_pixel_o),
    .direct_o    (out_direct_o),
    .last_o      (out_last_o)
  );

  assert_frame_drain_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (out_fire && out_last_o && !frame_start_i) |=> (!out_valid_o && !in_ready_o));
endmodule

// File: tb/pix_unpack_pal_test.sv
module pix_unpack_pal_test;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        frame_start_i = 1'b0;
  logic [2:0]  depth_sel_i = 3'd0;
  logic        active_panel_i = 1'b0;
  logic        color_mode_i = 1'b0;
  logic        pal_we_i = 1'b0;
  logic [7:0]  pal_waddr_i = 8'd0;
  logic [15:0] pal_wdata_i = 16'd0;
  logic        pal_wack_o;
  logic        in_valid_i = 1'b0;
  logic [31:0] in_data_i = 32'd0;
  logic        in_last_i = 1'b0;
  logic        in_ready_o;
  logic        out_valid_o;
  logic        out_ready_i = 1'b0;
  logic [15:0] out_pixel_o;
  logic        out_direct_o;
  logic        out_last_o;

  always #10 clk_i = ~clk_i;

  pix_unpack_pal uut (
    .clk_i(clk_i), .rst_ni(rst_ni), .frame_start_i(frame_start_i),
    .depth_sel_i(depth_sel_i), .active_panel_i(active_panel_i),
    .color_mode_i(color_mode_i), .pal_we_i(pal_we_i), .pal_waddr_i(pal_waddr_i),
    .pal_wdata_i(pal_wdata_i), .pal_wack_o(pal_wack_o), .in_valid_i(in_valid_i),
    .in_data_i(in_data_i), .in_last_i(in_last_i), .in_ready_o(in_ready_o),
    .out_valid_o(out_valid_o), .out_ready_i(out_ready_i), .out_pixel_o(out_pixel_o),
    .out_direct_o(out_direct_o), .out_last_o(out_last_o)
  );

  int checks = 0;
  int fails = 0;
  logic [15:0] pal_ref [256];
  logic [31:0] fw [3];
  int cd = 0, ca = 0, cc = 0, total = 0, seen = 0;
  logic [15:0] lfsr = 16'hACE1;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [15:0] pal_val(input int i);
    logic [7:0] ii;
    ii = i[7:0];
    return {~ii, 8'(ii * 8'd3 + 8'd7)};
  endfunction

  // output side: pseudo-random ready, compare accepted pixels
  always @(negedge clk_i) begin
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    out_ready_i = (lfsr[1:0] != 2'b00);
    if (rst_ni && out_valid_o && out_ready_i) begin
      if (seen >= total) begin
        chk(1'b0, "R11 extra pixel", 32'(seen), 32'(total));
      end else begin
        int bits, ppw, j;
        logic [31:0] w, code, mask;
        logic [15:0] ent, exp;
        string tag;
        bits = 1 << cd;
        ppw  = 32 >> cd;
        w    = fw[seen / ppw];
        j    = seen % ppw;
        mask = (32'd1 << bits) - 32'd1;
        code = (w >> (j * bits)) & mask;
        ent  = pal_ref[code[7:0]];
        if (cd == 4) exp = code[15:0];
        else exp = (cc != 0) ? ent : {8'h00, ent[7:0]};
        tag = (cd == 4) ? "R5 R2 pixel" : (cd == 3) ? "R4 R2 R6 pixel" : "R3 R2 R6 pixel";
        chk(out_pixel_o == exp, tag, 32'(out_pixel_o), 32'(exp));
        chk(out_direct_o == ca[0], "R7 route", 32'(out_direct_o), 32'(ca[0]));
        chk(out_last_o == (seen == total - 1), "R11 last flag", 32'(out_last_o),
            32'(seen == total - 1));
        seen++;
      end
    end
  end

  task automatic send_word(input logic [31:0] d, input bit last);
    in_valid_i = 1'b1;
    in_data_i  = d;
    in_last_i  = last;
    while (!in_ready_o) begin
      @(negedge clk_i); #1;
    end
    @(negedge clk_i); #1;
    in_valid_i = 1'b0;
    in_last_i  = 1'b0;
  endtask

  task automatic run_frame(input int sel, input int act, input int col,
                           input logic [31:0] w0, input logic [31:0] w1, input logic [31:0] w2);
    fw[0] = w0; fw[1] = w1; fw[2] = w2;
    cd = (sel > 4) ? 4 : sel;
    ca = act; cc = col;
    seen = 0;
    total = 3 * (32 >> cd);
    @(negedge clk_i); #1;
    depth_sel_i = 3'(sel); active_panel_i = act[0]; color_mode_i = col[0];
    frame_start_i = 1'b1;
    @(negedge clk_i); #1;
    frame_start_i = 1'b0;
    // R10: scramble mode inputs mid-frame
    depth_sel_i = 3'(sel + 2); active_panel_i = ~act[0]; color_mode_i = ~col[0];
    // R9: write during frame must be refused
    pal_we_i = 1'b1; pal_waddr_i = 8'(sel * 7 + 1); pal_wdata_i = 16'hDEAD;
    #1;
    chk(pal_wack_o == 1'b0, "R9 write refused in frame", 32'(pal_wack_o), 32'd0);
    @(negedge clk_i); #1;
    pal_we_i = 1'b0;
    for (int i = 0; i < 3; i++) send_word(fw[i], i == 2);
    wait (seen == total);
    @(negedge clk_i); #1;
    chk(in_ready_o == 1'b0, "R11 in_ready after frame", 32'(in_ready_o), 32'd0);
    chk(out_valid_o == 1'b0, "R11 output empty after frame", 32'(out_valid_o), 32'd0);
  endtask

  initial begin
    repeat (150000) @(posedge clk_i);
    fails++;
    $display("FAIL R11 watchdog actual=hung expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk_i);
    chk(out_valid_o == 1'b0, "R1 out_valid in reset", 32'(out_valid_o), 32'd0);
    chk(out_last_o == 1'b0, "R1 out_last in reset", 32'(out_last_o), 32'd0);
    chk(in_ready_o == 1'b0, "R1 in_ready in reset", 32'(in_ready_o), 32'd0);
    rst_ni = 1'b1;
    @(negedge clk_i); #1;
    chk(in_ready_o == 1'b0, "R1 in_ready before frame", 32'(in_ready_o), 32'd0);
    // R9: load palette while idle, every write accepted
    for (int i = 0; i < 256; i++) begin
      pal_we_i = 1'b1; pal_waddr_i = 8'(i); pal_wdata_i = pal_val(i);
      pal_ref[i] = pal_val(i);
      #1;
      chk(pal_wack_o == 1'b1, "R9 idle write accepted", 32'(pal_wack_o), 32'd1);
      @(negedge clk_i); #1;
    end
    pal_we_i = 1'b0;
    for (int s = 0; s < 5; s++)
      for (int a = 0; a < 2; a++)
        for (int c = 0; c < 2; c++) begin
          int k;
          k = s * 4 + a * 2 + c + 1;
          run_frame(s, a, c, 32'h9E3779B9 * 32'(k) ^ 32'(k << 7),
                    32'h7F4A7C15 * 32'(k + 3) ^ 32'h00FF00F0,
                    32'hC2B2AE35 * 32'(k + 11));
        end
    // R9: accepted idle write changes the entry seen by the next frame
    @(negedge clk_i); #1;
    pal_we_i = 1'b1; pal_waddr_i = 8'h42; pal_wdata_i = 16'hBEEF;
    #1;
    chk(pal_wack_o == 1'b1, "R9 idle rewrite accepted", 32'(pal_wack_o), 32'd1);
    pal_ref[8'h42] = 16'hBEEF;
    @(negedge clk_i); #1;
    pal_we_i = 1'b0;
    run_frame(3, 0, 1, 32'h42FF4200, 32'h01420242, 32'h42424242);
    run_frame(3, 1, 0, 32'h42FF4200, 32'h80420242, 32'hFE0142FF);
    // R2: reserved depth codes behave as 16-bit
    run_frame(7, 1, 0, 32'hA5A55A5A, 32'h0000FFFF, 32'h12345678);
    run_frame(5, 0, 1, 32'hFFFF0000, 32'h8001F00F, 32'hCAFEBABE);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule